// File: doc/BRIEF.md
# Guarded Clock-Source Control Register Block

This block is a small register peripheral on a two-phase APB-style bus. It keeps a clock generator's enable and connect flags and its configuration field in staged (shadow) registers. A write to the control or configuration register changes only the staged copy. The staged values are copied into the active registers only when software writes a two-step key to a dedicated feed register: 0xAA, and then 0x55 as the very next bus access. A stray write therefore cannot retune or switch the system clock.

The active enable and connect flags drive a source-select output. The output chooses the PLL clock only when both flags are set; in every other case the oscillator clock is used. A connect flag without an enable flag acts as if both were clear. Software is expected to enable the PLL first, wait for lock, and then connect it.

A lock indication from the PLL passes through a configurable synchronizer. It appears in a read-only status register and on a level interrupt request line, so software does not have to poll for lock. A power-down input clears the active connect flag. The status register also reads back the active enable, connect and configuration values.

Top module: `clkctl_guard`

## Requirements
- R1: After reset every register reads 0, `pll_sel` is 0 (oscillator clock) and `lock_irq` is 0.
- R2: A write to control (offset 0x0; bit 0 = enable, bit 1 = connect) or configuration (offset 0x4; low CFG_W bits) updates only the staged copy. That copy reads back at the same offset, and `pll_sel` and the status register stay unchanged.
- R3: A feed write (offset 0xC) of exactly 0x00AA, followed by a feed write of exactly 0x0055 as the next bus access, copies the staged control and configuration into the active registers at the clock edge of the 0x55 access.
- R4: Any other access between the two feed writes, or any feed value other than the expected one (this includes 0x55 with no 0xAA before it), voids the sequence. The active registers are left unchanged, and a new 0xAA is needed.
- R5: A 0xAA feed write while the block is waiting for 0x55 restarts the sequence, so 0xAA, 0xAA, 0x55 commits.
- R6: `pll_sel` is 1 exactly when the active enable and the active connect are both 1. Connect=1 with enable=0 keeps `pll_sel` at 0.
- R7: The status register (offset 0x8) has the active configuration in bits CFG_W-1:0, active enable in bit 8, active connect in bit 9 and lock in bit 10. All other bits read 0, and writes to it have no effect.
- R8: While `pwrdn` is 1, the active connect is cleared at each clock edge, and this overrides a commit in the same cycle. It is not restored when `pwrdn` falls.
- R9: `lock_in` reaches status bit 10 and `lock_irq` after exactly SYNC_STAGES clock edges. `lock_irq` always equals status bit 10.
- R10: Reads of the feed offset, or of any offset other than 0x0, 0x4, 0x8 and 0xC, return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid while selected for a read |
| lock_in | input | 1 | PLL lock indication (asynchronous) |
| pwrdn | input | 1 | Power-down active |
| pll_sel | output | 1 | 1 = PLL clock selected, 0 = oscillator clock |
| lock_irq | output | 1 | Level interrupt request on lock |

## Verification
The bench builds the block with its default parameters: a 4-bit address, 16-bit data, a 7-bit configuration field and a two-stage lock synchronizer. With 16-bit data the reserved status bits 15:11 can be observed. Bit 7 of the status register sits between the configuration field and the enable bit, so a field that spills over its width would show there. The two-stage synchronizer makes the lock latency a measurable two-edge window, which the bench checks both before and after it expires.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   typedef enum logic [1:0] {
      FEED_IDLE  = 2'd0,
      FEED_ARMED = 2'd1
   } feed_state_e;

   typedef struct packed {
      logic connect;
      logic enable;
   } ctrl_t;

   localparam int STAT_EN_BIT   = 8;
   localparam int STAT_CON_BIT  = 9;
   localparam int STAT_LOCK_BIT = 10;
   localparam int STAT_MIN_W    = 16;
   localparam int CFG_MAX_W     = 8;

endpackage

// File: rtl/clkctl_feed_seq.sv
module clkctl_feed_seq
   import clkctl_pkg::*;
#(
   parameter int          DATA_W     = 16,
   parameter logic [7:0]  KEY_FIRST  = 8'hAA,
   parameter logic [7:0]  KEY_SECOND = 8'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              access,
   input  logic              feed_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              commit
);

   localparam logic [DATA_W-1:0] FIRST_W  = DATA_W'(KEY_FIRST);
   localparam logic [DATA_W-1:0] SECOND_W = DATA_W'(KEY_SECOND);

   feed_state_e state_q;
   logic        first_hit;

   assign first_hit = feed_wr && (wdata == FIRST_W);
   assign commit    = access && feed_wr && (state_q == FEED_ARMED) && (wdata == SECOND_W);

   // Every completed access moves the sequence: the key restarts it, anything else voids it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FEED_IDLE;
      end else if (access) begin
         state_q <= first_hit ? FEED_ARMED : FEED_IDLE;
      end
   end

endmodule

// File: rtl/clkctl_lock_sync.sv
module clkctl_lock_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] ff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ff_q <= '0;
            end else begin
               ff_q[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  ff_q[i] <= ff_q[i-1];
               end
            end
         end
         assign q = ff_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/clkctl_rd_mux.sv
module clkctl_rd_mux
   import clkctl_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CFG_W  = 7
) (
   input  logic              rd_en,
   input  logic              hit_ctrl,
   input  logic              hit_cfg,
   input  logic              hit_stat,
   input  ctrl_t             sh_ctrl,
   input  logic [CFG_W-1:0]  sh_cfg,
   input  ctrl_t             act_ctrl,
   input  logic [CFG_W-1:0]  act_cfg,
   input  logic              lock,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] stat_word;

   always_comb begin
      stat_word                = '0;
      stat_word[CFG_W-1:0]     = act_cfg;
      stat_word[STAT_EN_BIT]   = act_ctrl.enable;
      stat_word[STAT_CON_BIT]  = act_ctrl.connect;
      stat_word[STAT_LOCK_BIT] = lock;
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (hit_ctrl) begin
            rdata[0] = sh_ctrl.enable;
            rdata[1] = sh_ctrl.connect;
         end else if (hit_cfg) begin
            rdata[CFG_W-1:0] = sh_cfg;
         end else if (hit_stat) begin
            rdata = stat_word;
         end
      end
   end

endmodule

// File: rtl/clkctl_guard.sv
module clkctl_guard
   import clkctl_pkg::*;
#(
   parameter int          ADDR_W      = 4,
   parameter int          DATA_W      = 16,
   parameter int          CFG_W       = 7,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  KEY_FIRST   = 8'hAA,
   parameter logic [7:0]  KEY_SECOND  = 8'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   input  logic              lock_in,
   input  logic              pwrdn,
   output logic              pll_sel,
   output logic              lock_irq
);

   localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(4'h0);
   localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(4'h4);
   localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4'h8);
   localparam logic [ADDR_W-1:0] OFS_FEED = ADDR_W'(4'hC);

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("clkctl_guard: ADDR_W must be at least 4");
      end
      if (DATA_W < STAT_MIN_W) begin : g_bad_data
         $error("clkctl_guard: DATA_W must hold the 16-bit status word");
      end
      if (CFG_W < 1 || CFG_W > CFG_MAX_W) begin : g_bad_cfg
         $error("clkctl_guard: CFG_W must be 1..8");
      end
   endgenerate

   logic             access, wr, rd_en;
   logic             hit_ctrl, hit_cfg, hit_stat, hit_feed;
   logic             commit, lock_s;
   ctrl_t            sh_ctrl, act_ctrl;
   logic [CFG_W-1:0] sh_cfg, act_cfg;

   assign access   = psel && penable;
   assign wr       = access && pwrite;
   assign rd_en    = psel && !pwrite;
   assign hit_ctrl = (paddr == OFS_CTRL);
   assign hit_cfg  = (paddr == OFS_CFG);
   assign hit_stat = (paddr == OFS_STAT);
   assign hit_feed = (paddr == OFS_FEED);

   // Staged copies written directly by software.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_ctrl <= '0;
         sh_cfg  <= '0;
      end else if (wr) begin
         if (hit_ctrl) begin
            sh_ctrl.enable  <= pwdata[0];
            sh_ctrl.connect <= pwdata[1];
         end
         if (hit_cfg) begin
            sh_cfg <= pwdata[CFG_W-1:0];
         end
      end
   end

   // Active copies: loaded by the unlock key, connect cleared by power-down (wins).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_ctrl <= '0;
         act_cfg  <= '0;
      end else begin
         if (commit) begin
            act_ctrl <= sh_ctrl;
            act_cfg  <= sh_cfg;
         end
         if (pwrdn) begin
            act_ctrl.connect <= 1'b0;
         end
      end
   end

   clkctl_feed_seq #(
      .DATA_W     (DATA_W),
      .KEY_FIRST  (KEY_FIRST),
      .KEY_SECOND (KEY_SECOND)
   ) u_feed (
      .clk     (clk),
      .rst_n   (rst_n),
      .access  (access),
      .feed_wr (pwrite && hit_feed),
      .wdata   (pwdata),
      .commit  (commit)
   );

   clkctl_lock_sync #(
      .STAGES (SYNC_STAGES)
   ) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (lock_in),
      .q     (lock_s)
   );

   clkctl_rd_mux #(
      .DATA_W (DATA_W),
      .CFG_W  (CFG_W)
   ) u_rd (
      .rd_en    (rd_en),
      .hit_ctrl (hit_ctrl),
      .hit_cfg  (hit_cfg),
      .hit_stat (hit_stat),
      .sh_ctrl  (sh_ctrl),
      .sh_cfg   (sh_cfg),
      .act_ctrl (act_ctrl),
      .act_cfg  (act_cfg),
      .lock     (lock_s),
      .rdata    (prdata)
   );

   assign pll_sel  = act_ctrl.enable && act_ctrl.connect;
   assign lock_irq = lock_s;

endmodule

// File: rtl/clkctl_guard_chk.sv
module clkctl_guard_chk #(
   parameter int         ADDR_W     = 4,
   parameter int         DATA_W     = 16,
   parameter logic [7:0] KEY_SECOND = 8'h55
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [DATA_W-1:0] pwdata,
   input logic [DATA_W-1:0] prdata,
   input logic              pwrdn,
   input logic              pll_sel,
   input logic              lock_irq,
   input logic              commit
);

   logic stat_rd;
   assign stat_rd = psel && !pwrite && (paddr == ADDR_W'(4'h8));

   // R1: leaving reset, the oscillator is selected
   a_r1_reset_osc: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !pll_sel);

   // R3: the PLL is only ever selected by an unlock commit
   a_r3_sel_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_sel) |-> $past(commit));

   // R4: a commit only happens on a completed feed write of the second key
   a_r4_commit_on_key: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (psel && penable && pwrite && paddr == ADDR_W'(4'hC)
                  && pwdata == DATA_W'(KEY_SECOND)));

   // R8: power-down deselects the PLL at the next edge
   a_r8_pwrdn_drops: assert property (@(posedge clk) disable iff (!rst_n)
      pwrdn |=> !pll_sel);

   // R7: reserved status bits read 0
   a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |-> (prdata[DATA_W-1:11] == '0 && prdata[7] == 1'b0));

   // R9: interrupt request mirrors the lock status bit
   a_r9_irq_matches_stat: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |-> (prdata[10] == lock_irq));

endmodule

bind clkctl_guard clkctl_guard_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .KEY_SECOND (KEY_SECOND)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .psel     (psel),
   .penable  (penable),
   .pwrite   (pwrite),
   .paddr    (paddr),
   .pwdata   (pwdata),
   .prdata   (prdata),
   .pwrdn    (pwrdn),
   .pll_sel  (pll_sel),
   .lock_irq (lock_irq),
   .commit   (commit)
);

// File: tb/clkctl_guard_tb.sv
module clkctl_guard_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 4;
   localparam int DATA_W     = 16;
   localparam int CFG_W      = 7;
   localparam int SYNC       = 2;

   localparam logic [3:0] A_CTRL = 4'h0;
   localparam logic [3:0] A_CFG  = 4'h4;
   localparam logic [3:0] A_STAT = 4'h8;
   localparam logic [3:0] A_FEED = 4'hC;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [ADDR_W-1:0] paddr = '0;
   logic [DATA_W-1:0] pwdata = '0;
   logic [DATA_W-1:0] prdata;
   logic              lock_in = 1'b0, pwrdn = 1'b0;
   logic              pll_sel, lock_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // bench model of the requirements
   logic             m_sh_en, m_sh_con, m_en, m_con, m_armed, m_lock;
   logic [CFG_W-1:0] m_sh_cfg, m_cfg;

   always #(CLK_PERIOD/2) clk = ~clk;

   clkctl_guard #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W), .SYNC_STAGES(SYNC)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .lock_in(lock_in),
      .pwrdn(pwrdn), .pll_sel(pll_sel), .lock_irq(lock_irq)
   );

   function automatic logic [DATA_W-1:0] exp_stat();
      logic [DATA_W-1:0] s = '0;
      s[CFG_W-1:0] = m_cfg;
      s[8]  = m_en;
      s[9]  = m_con;
      s[10] = m_lock;
      return s;
   endfunction

   function automatic logic [DATA_W-1:0] exp_read(input logic [3:0] a);
      case (a)
         A_CTRL:  return {{(DATA_W-2){1'b0}}, m_sh_con, m_sh_en};
         A_CFG:   return DATA_W'(m_sh_cfg);
         A_STAT:  return exp_stat();
         default: return '0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_access(input logic [3:0] a, input logic w, input logic [DATA_W-1:0] d);
      logic hit;
      hit = w && a == A_FEED && d == 16'h0055 && m_armed;
      if (w && a == A_CTRL) begin m_sh_en = d[0]; m_sh_con = d[1]; end
      if (w && a == A_CFG)  m_sh_cfg = d[CFG_W-1:0];
      m_armed = w && a == A_FEED && d == 16'h00AA;
      if (hit) begin m_en = m_sh_en; m_con = m_sh_con; m_cfg = m_sh_cfg; end
      if (pwrdn) m_con = 1'b0;
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      model_access(a, 1'b1, d);
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [DATA_W-1:0] d);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      @(negedge clk);
      penable = 1'b1;
      #1 d = prdata;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
      model_access(a, 1'b0, '0);
   endtask

   task automatic read_check(input string tag, input logic [3:0] a);
      logic [DATA_W-1:0] d, e;
      e = exp_read(a);
      bus_read(a, d);
      check(tag, d, e);
   endtask

   task automatic port_check(input string tag);
      check({tag, " pll_sel"}, DATA_W'(pll_sel), DATA_W'(m_en & m_con));
      check({tag, " lock_irq"}, DATA_W'(lock_irq), DATA_W'(m_lock));
   endtask

   task automatic feed_pair();
      bus_write(A_FEED, 16'h00AA);
      bus_write(A_FEED, 16'h0055);
   endtask

   task automatic set_pwrdn(input logic v);
      @(negedge clk);
      pwrdn = v;
      @(negedge clk);
      if (pwrdn) m_con = 1'b0;
   endtask

   initial begin
      logic [DATA_W-1:0] d;
      void'($urandom(32'd4213));
      m_sh_en = 0; m_sh_con = 0; m_en = 0; m_con = 0; m_armed = 0; m_lock = 0;
      m_sh_cfg = '0; m_cfg = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      port_check("R1 reset");
      read_check("R1 ctrl", A_CTRL);
      read_check("R1 cfg", A_CFG);
      read_check("R1 stat", A_STAT);

      // R2 staged writes have no active effect
      bus_write(A_CTRL, 16'h0003);
      bus_write(A_CFG, 16'h0055);
      read_check("R2 ctrl readback", A_CTRL);
      read_check("R2 cfg readback", A_CFG);
      read_check("R2 stat untouched", A_STAT);
      port_check("R2");

      // R3 unlock commits, R6 both bits set selects PLL
      feed_pair();
      check("R3 pll_sel after key", DATA_W'(pll_sel), 16'd1);
      read_check("R3 stat active", A_STAT);
      port_check("R6 both");

      // R4 intervening access voids
      bus_write(A_CTRL, 16'h0002);
      bus_write(A_FEED, 16'h00AA);
      read_check("R4 intervening read", A_CFG);
      bus_write(A_FEED, 16'h0055);
      check("R4 no commit after break", DATA_W'(pll_sel), 16'd1);
      // wrong values and lone second key
      bus_write(A_FEED, 16'h01AA);
      bus_write(A_FEED, 16'h0055);
      bus_write(A_FEED, 16'h00AA);
      bus_write(A_FEED, 16'h0056);
      bus_write(A_FEED, 16'h0055);
      read_check("R4 stat after bad keys", A_STAT);
      check("R4 pll_sel after bad keys", DATA_W'(pll_sel), 16'd1);

      // R5 restart on repeated first key; R6 connect without enable
      bus_write(A_FEED, 16'h00AA);
      bus_write(A_FEED, 16'h00AA);
      bus_write(A_FEED, 16'h0055);
      check("R6 connect-only keeps osc", DATA_W'(pll_sel), 16'd0);
      read_check("R5 restart committed", A_STAT);

      // R7 status writes ignored
      bus_write(A_STAT, 16'hFFFF);
      read_check("R7 stat write ignored", A_STAT);

      // R10 unmapped and feed reads return 0, writes ignored
      bus_write(4'h2, 16'hFFFF);
      read_check("R10 unmapped read", 4'h2);
      read_check("R10 feed read", A_FEED);
      read_check("R10 ctrl unchanged", A_CTRL);

      // R8 power-down clears connect
      bus_write(A_CTRL, 16'h0003);
      feed_pair();
      port_check("R8 before");
      set_pwrdn(1'b1);
      check("R8 pll_sel in pwrdn", DATA_W'(pll_sel), 16'd0);
      feed_pair();
      check("R8 pwrdn beats commit", DATA_W'(pll_sel), 16'd0);
      set_pwrdn(1'b0);
      read_check("R8 connect not restored", A_STAT);

      // R9 lock latency
      @(negedge clk);
      lock_in = 1'b1;
      @(negedge clk);
      check("R9 lock not yet through", DATA_W'(lock_irq), 16'd0);
      @(negedge clk);
      check("R9 lock after stages", DATA_W'(lock_irq), 16'd1);
      m_lock = 1'b1;
      read_check("R9 stat lock bit", A_STAT);

      // random mix
      for (int i = 0; i < 400; i++) begin
         int op;
         op = $urandom % 10;
         case (op)
            0: bus_write(A_CTRL, DATA_W'($urandom));
            1: bus_write(A_CFG, DATA_W'($urandom));
            2, 3: bus_write(A_FEED, 16'h00AA);
            4, 5: bus_write(A_FEED, 16'h0055);
            6: bus_write(A_FEED, ($urandom % 2) ? DATA_W'($urandom) : 16'h00AA);
            7: read_check("R3 random stat", A_STAT);
            8: begin
               if ($urandom % 4 == 0) set_pwrdn(~pwrdn);
               else read_check("R2 random ctrl", A_CTRL);
            end
            default: begin
               @(negedge clk);
               lock_in = ~lock_in;
               repeat (SYNC) @(negedge clk);
               m_lock = lock_in;
            end
         endcase
         port_check("R6 random");
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule